// File: doc/BRIEF.md
# Audio FIFO Sample Unpacker

This block sits between a playback FIFO and a serial digital-audio line encoder. It accepts one 64-bit word at a time and splits it into fixed-size containers of 8, 16 or 32 bits. Each container is right-justified inside its slot. The block trims each container to its significant bits and places that sample in the 24-bit audio field of a subframe. The sample's most significant bit always lands at bit 23 of that field.

Three configuration inputs control the block: the container size, the bit index of the sample's top bit, and a two-bit channel mask that selects mono or stereo. Samples leave on a valid/ready stream and each one is tagged as left or right. In stereo, the slots of a word are sent lowest first and alternate left, right. In mono, every slot is sent twice, once as left and once as right. The configuration must be held stable while a word is being unpacked.

Top module: `fifo_sample_unpacker`

## Requirements
- R1: After reset, `smp_valid` is 0 and `word_ready` is 1.
- R2: A word is taken on a clock edge where `word_valid` and `word_ready` are both 1. Its first sample is valid in the next cycle.
- R3: When `cfg_type` is 0, the word holds eight 8-bit slots, and slot k is bits [8k+7:8k].
- R4: When `cfg_type` is 2, the word holds four 16-bit slots, and slot k is bits [16k+15:16k].
- R5: When `cfg_type` is 4, or any code other than 0 and 2, the word holds two 32-bit slots, and slot k is bits [32k+31:32k].
- R6: Slot bits above `cfg_msb`, or above the container, read as zero. Bit `cfg_msb` of the slot appears at `smp_data[23]`. When `cfg_msb` is below 23, the bits of `smp_data` under the sample are zero.
- R7: When `cfg_msb` is above 23, slot bits below index `cfg_msb`-23 are dropped.
- R8: When `cfg_chmask` is not 2'b01 (stereo), slots are sent from slot 0 upward. `smp_right` is 0 for even slots and 1 for odd slots.
- R9: When `cfg_chmask` is 2'b01 (mono), every slot is sent twice with the same data: first with `smp_right` at 0, then with `smp_right` at 1.
- R10: While `smp_valid` is 1 and `smp_ready` is 0, `smp_data` and `smp_right` hold their values.
- R11: `word_ready` stays 0 while any sample of the current word is still pending. It returns to 1 in the cycle after the last sample of the word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A FIFO word is offered |
| word_data | input | 64 | The offered FIFO word |
| word_ready | output | 1 | The block takes a word on this edge |
| cfg_type | input | 3 | Container size code: 0 = 8 bits, 2 = 16 bits, other codes = 32 bits |
| cfg_msb | input | 5 | Bit index of the sample's top bit inside its container |
| cfg_chmask | input | 2 | Channel mask: 2'b01 = mono, any other value = stereo |
| smp_valid | output | 1 | A sample is presented |
| smp_ready | input | 1 | The downstream stage accepts the sample |
| smp_data | output | 24 | Sample, aligned to the top of the audio field |
| smp_right | output | 1 | 0 = left subframe, 1 = right subframe |

## Verification
Two events can fall in the same cycle: acceptance of the final sample of a word, and the request for the next word. A new word is offered as soon as the previous one is drained. The bench then checks that `word_ready` is still 0 while that final sample is being presented, and that it rises only one cycle later. Backpressure can also coincide with the mono duplication step. The bench stalls `smp_ready` on both the left copy and the right copy of each mono slot, and checks that neither the data nor the tag moves during the stall.

// File: rtl/fifo_sample_unpacker.sv
module fifo_sample_unpacker #(
  parameter int WORD_W = 64,
  parameter int AUD_W  = 24,
  parameter int MSB_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic [2:0]        cfg_type,
  input  logic [MSB_W-1:0]  cfg_msb,
  input  logic [1:0]        cfg_chmask,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [AUD_W-1:0]  smp_data,
  output logic              smp_right
);
  localparam int IDX_W = $clog2(WORD_W / 8);
  localparam int TOP   = AUD_W - 1;

  logic [WORD_W-1:0] word_q;
  logic              full, phase;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [2:0]        cw_log;
  logic [31:0]       raw;
  logic              mono, last_beat;

  assign mono       = cfg_chmask == 2'b01;
  assign word_ready = !full;
  assign smp_valid  = full;
  assign smp_right  = mono ? phase : idx[0];
  assign cw_log     = (cfg_type == 3'd0) ? 3'd3 : (cfg_type == 3'd2) ? 3'd4 : 3'd5;
  assign last_idx   = IDX_W'((WORD_W >> cw_log) - 1);
  assign last_beat  = (idx == last_idx) && (!mono || phase);

  always_comb begin
    logic [WORD_W-1:0] shifted;
    logic [32:0]       keep;
    shifted = word_q >> ({{(WORD_W-IDX_W){1'b0}}, idx} << cw_log);
    keep    = (33'd2 << cfg_msb) - 33'd1;
    raw     = shifted[31:0] & keep[31:0] & ((32'd1 << (32'd1 << cw_log)) - 32'd1 | {32{cw_log == 3'd5}});
    if (int'(cfg_msb) >= TOP) smp_data = AUD_W'(raw >> (int'(cfg_msb) - TOP));
    else                      smp_data = AUD_W'(raw << (TOP - int'(cfg_msb)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      full   <= 1'b0;
      phase  <= 1'b0;
      idx    <= '0;
    end else if (word_valid && word_ready) begin
      word_q <= word_data;
      full   <= 1'b1;
      phase  <= 1'b0;
      idx    <= '0;
    end else if (smp_valid && smp_ready) begin
      if (mono && !phase) phase <= 1'b1;
      else begin
        phase <= 1'b0;
        if (last_beat) full <= 1'b0;
        else           idx  <= idx + 1'b1;
      end
    end
  end

  a_r2_load_presents: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready |=> smp_valid);
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(smp_right));
  a_r11_req_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) |-> $past(smp_valid && smp_ready));
  a_r9_mono_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && mono && !smp_right |=> smp_valid && smp_right && $stable(smp_data));
  a_r8_stereo_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !mono && !smp_right |=> smp_valid && smp_right);
endmodule

// File: tb/sim_fifo_sample_unpacker.sv
`timescale 1ns/1ps
module sim_fifo_sample_unpacker;
  logic clk = 0, rst_n = 0;
  logic word_valid = 0, smp_ready = 0;
  logic [63:0] word_data = '0;
  logic [2:0] cfg_type = 0;
  logic [4:0] cfg_msb = 0;
  logic [1:0] cfg_chmask = 2'b11;
  logic word_ready, smp_valid, smp_right;
  logic [23:0] smp_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  fifo_sample_unpacker u0 (.clk, .rst_n, .word_valid, .word_data, .word_ready,
    .cfg_type, .cfg_msb, .cfg_chmask, .smp_valid, .smp_ready, .smp_data, .smp_right);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_smp(input logic [63:0] w, input logic [2:0] t,
                                          input logic [4:0] m, input int slot);
    int cw = (t == 0) ? 8 : (t == 2) ? 16 : 32;
    logic [31:0] v = '0;
    logic [23:0] r = '0;
    for (int b = 0; b < cw; b++) if (b <= m) v[b] = w[slot*cw + b];
    for (int j = 0; j < 24; j++) begin
      int src = int'(m) - 23 + j;
      if (src >= 0) r[j] = v[src];
    end
    return r;
  endfunction

  task automatic run_word(input logic [63:0] w, input logic [2:0] t, input logic [4:0] m,
                          input logic [1:0] cm, input bit stall, input string rq);
    int cw = (t == 0) ? 8 : (t == 2) ? 16 : 32;
    int n = 64 / cw;
    bit mono = (cm == 2'b01);
    int beats = mono ? 2*n : n;
    @(negedge clk);
    cfg_type = t; cfg_msb = m; cfg_chmask = cm; word_data = w; word_valid = 1; smp_ready = 0;
    chk(word_ready == 1, "R2 ready before load", {31'd0, word_ready}, 1);
    @(negedge clk);
    word_valid = 0;
    for (int b = 0; b < beats; b++) begin
      int slot = mono ? b/2 : b;
      bit rt = mono ? b[0] : slot[0];
      logic [23:0] e = exp_smp(w, t, m, slot);
      chk(smp_valid && smp_data == e && smp_right == rt, rq,
          {7'd0, smp_valid, smp_right, smp_data}, {7'd0, 1'b1, rt, e});
      chk(word_ready == 0, "R11 no request while pending", {31'd0, word_ready}, 0);
      if (stall) begin
        @(negedge clk);
        chk(smp_valid && smp_data == e && smp_right == rt, "R10 hold under stall",
            {7'd0, smp_valid, smp_right, smp_data}, {7'd0, 1'b1, rt, e});
      end
      smp_ready = 1;
      @(negedge clk);
      smp_ready = 0;
    end
    chk(!smp_valid && word_ready, "R11 request after last",
        {30'd0, smp_valid, word_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(!smp_valid && word_ready, "R1 reset state", {30'd0, smp_valid, word_ready}, 32'd1);
  endtask
  task automatic t_bytes_stereo;
    run_word(64'h8877_6655_4433_2211, 3'd0, 5'd7, 2'b11, 0, "R3 R8 byte slots stereo");
  endtask
  task automatic t_halves_stall;
    run_word(64'hF00D_BEEF_1234_ABCD, 3'd2, 5'd15, 2'b11, 1, "R4 R10 16-bit slots stalled");
  endtask
  task automatic t_narrow;
    run_word(64'hFFFF_A5A5_F123_0F0F, 3'd2, 5'd11, 2'b11, 0, "R6 12-bit in 16-bit container");
  endtask
  task automatic t_word24;
    run_word(64'hAA12_3456_FF65_4321, 3'd4, 5'd23, 2'b11, 0, "R5 R6 24-bit in 32-bit");
  endtask
  task automatic t_word32;
    run_word(64'h89AB_CDEF_0123_4567, 3'd4, 5'd31, 2'b00, 0, "R7 32-bit samples truncated");
  endtask
  task automatic t_other_code;
    run_word(64'h1357_9BDF_2468_ACE0, 3'd5, 5'd19, 2'b10, 0, "R5 unknown code as 32-bit");
  endtask
  task automatic t_mono;
    run_word(64'h0102_0304_0506_0708, 3'd0, 5'd7, 2'b01, 1, "R9 mono duplicate");
  endtask
  task automatic t_mono_halves;
    run_word(64'hC001_D00D_7E57_0BAD, 3'd2, 5'd15, 2'b01, 0, "R9 mono 16-bit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bytes_stereo();
    t_halves_stall();
    t_narrow();
    t_word24();
    t_word32();
    t_other_code();
    t_mono();
    t_mono_halves();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule